// File: doc/BRIEF.md
# Ping-Pong Block Transfer Controller

This block moves a stream of samples into two alternating buffer regions, so that a processor can work on one region while the other fills. Each accepted sample goes out on a memory write port. The write address is the base of the buffer currently being filled plus the sample's position in the block. The transfer is shaped by two counts: elements per frame and frames per block. One block therefore holds N = elements × frames samples. The processor takes no part while a block is moving.

A block ends with the last element of its last frame. At that point the two buffers swap roles automatically, a one-cycle block pulse is raised, and an indicator names the buffer that now holds a full block for the processor. The processor acknowledges that it has consumed a buffer. If a swap comes due while the previously delivered buffer is still unacknowledged, a sticky overrun flag is set and the swap happens anyway. A source address that tracks the position of the next expected sample is also presented, for upstream logic that needs it. Deasserting the enable restarts the engine from a clean state.

Top module: `pingpong_dma`

## Requirements
- R1: After reset, wrEn, frameDone, blockDone, overrun, fillBuf and readyBuf are all 0.
- R2: inReady equals cfgEnable. A sample is accepted on a clock edge where inValid and inReady are both high. In the following cycle, wrEn is 1 and wrData carries that sample.
- R3: Every write goes to wrAddr = base of the fill buffer + position in block, modulo 2^ADDR_W. The position is frame index × elements per frame + element index. The fill buffer base is cfgBufBase0 when the fill buffer is 0 and cfgBufBase1 when it is 1. wrBuf gives the number of the buffer being written.
- R4: frameDone is high for exactly the cycle in which the last element of a frame is written.
- R5: blockDone is high for exactly the cycle in which the last element of the last frame is written. In that same cycle fillBuf has toggled, and readyBuf names the buffer just completed. readyBuf holds until the next block ends.
- R6: The first write after a block ends goes to position 0 of the newly selected buffer.
- R7: srcAddr equals cfgSrcBase + the block position of the next sample to be accepted, modulo 2^ADDR_W.
- R8: When a block ends while the previously delivered buffer is unacknowledged, overrun becomes 1 and stays 1, and the swap still occurs. The previously delivered buffer is acknowledged by a procAck pulse at any time after its blockDone, including in the very cycle the next block completes. A procAck given while no buffer is outstanding has no effect.
- R9: With cfgEnable low, no sample is accepted and nothing is written, even while inValid is high. The element and frame counts, fillBuf, readyBuf, the pending acknowledgement and overrun all return to 0.
- R10: Cycles without an accepted sample produce no write and no pulses, and they leave the position in the block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Run enable; low restarts the engine |
| cfgSrcBase | input | ADDR_W | Source base address |
| cfgBufBase0 | input | ADDR_W | Base address of buffer 0 |
| cfgBufBase1 | input | ADDR_W | Base address of buffer 1 |
| cfgElemCount | input | CNT_W | Elements per frame (at least 1) |
| cfgFrameCount | input | CNT_W | Frames per block (at least 1) |
| inValid | input | 1 | Input sample valid |
| inData | input | DATA_W | Input sample |
| inReady | output | 1 | Input sample ready |
| srcAddr | output | ADDR_W | Source address of the next sample |
| wrEn | output | 1 | Buffer write strobe |
| wrBuf | output | 1 | Buffer number being written |
| wrAddr | output | ADDR_W | Buffer write address |
| wrData | output | DATA_W | Buffer write data |
| frameDone | output | 1 | One-cycle pulse on the last write of a frame |
| blockDone | output | 1 | One-cycle pulse on the last write of a block |
| fillBuf | output | 1 | Buffer currently being filled |
| readyBuf | output | 1 | Buffer holding the latest completed block |
| procAck | input | 1 | Processor has consumed the ready buffer |
| overrun | output | 1 | Sticky: a swap occurred before acknowledgement |

## Verification
The bench builds the block with ADDR_W = 8, CNT_W = 4 and DATA_W = 16. It sweeps every shape from 1 to 4 elements per frame by 1 to 3 frames per block, which includes the single-sample block where frame end, block end and swap all fall on the same write. Each shape runs for more than two blocks, so both buffers are filled and both swap directions occur. Single idle cycles are interleaved with back-to-back acceptance. Separate runs cover the acknowledgement cases: an acknowledgement that arrives too late, one that arrives in the completing cycle, and a stray one given while nothing is outstanding.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  // Strobes from control to datapath, valid in the cycle of acceptance.
  typedef struct packed {
    logic accept;    // a sample is taken this cycle
    logic frameEnd;  // accepted sample is last of its frame
    logic blockEnd;  // accepted sample is last of its block
    logic fillSel;   // buffer being filled before this edge
    logic restart;   // engine disabled, clear position
  } ppStrobe_t;

endpackage

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [CNT_W-1:0] cfgElemCount,
  input  logic [CNT_W-1:0] cfgFrameCount,
  input  logic             inValid,
  input  logic             procAck,
  output logic             inReady,
  output ppStrobe_t        strb,
  output logic             frameDone,
  output logic             blockDone,
  output logic             fillBuf,
  output logic             readyBuf,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] elemIdx;
  logic [CNT_W-1:0] frameIdx;
  logic             pending;
  logic             accept;
  logic             lastElem;
  logic             lastFrame;

  assign inReady   = cfgEnable;
  assign accept    = inValid && inReady;
  assign lastElem  = (elemIdx == cfgElemCount - ONE);
  assign lastFrame = (frameIdx == cfgFrameCount - ONE);

  always_comb begin
    strb.accept   = accept;
    strb.frameEnd = accept && lastElem;
    strb.blockEnd = accept && lastElem && lastFrame;
    strb.fillSel  = fillBuf;
    strb.restart  = !cfgEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elemIdx   <= '0;
      frameIdx  <= '0;
      fillBuf   <= 1'b0;
      readyBuf  <= 1'b0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
      frameDone <= 1'b0;
      blockDone <= 1'b0;
    end else if (!cfgEnable) begin
      elemIdx   <= '0;
      frameIdx  <= '0;
      fillBuf   <= 1'b0;
      readyBuf  <= 1'b0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
      frameDone <= 1'b0;
      blockDone <= 1'b0;
    end else begin
      frameDone <= strb.frameEnd;
      blockDone <= strb.blockEnd;
      if (accept) begin
        if (lastElem) begin
          elemIdx <= '0;
          if (lastFrame) frameIdx <= '0;
          else           frameIdx <= frameIdx + ONE;
        end else begin
          elemIdx <= elemIdx + ONE;
        end
      end
      if (strb.blockEnd) begin
        fillBuf  <= ~fillBuf;
        readyBuf <= fillBuf;
        pending  <= 1'b1;
        if (pending && !procAck) overrun <= 1'b1;
      end else if (procAck) begin
        pending <= 1'b0;
      end
    end
  end

  // R4/R5: a block end is always also a frame end
  p_block_implies_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> frameDone);

  // R5: roles exchange in the cycle the block pulse appears
  p_swap_toggles_r5: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> (fillBuf != $past(fillBuf)) && (readyBuf == $past(fillBuf)));

  // R8: overrun can only appear together with a swap
  p_overrun_on_swap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> blockDone);

  // R5: ready indicator changes only on a swap or a restart
  p_ready_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!blockDone && $past(cfgEnable)) |-> $stable(readyBuf));

endmodule

// File: rtl/pp_dma_datapath.sv
module pp_dma_datapath
  import pp_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ppStrobe_t         strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [ADDR_W-1:0] cfgSrcBase,
  input  logic [ADDR_W-1:0] cfgBufBase0,
  input  logic [ADDR_W-1:0] cfgBufBase1,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              wrEn,
  output logic              wrBuf,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] blkOff;
  logic [ADDR_W-1:0] bufBase [2];
  logic [ADDR_W-1:0] dstBase;

  assign bufBase[0] = cfgBufBase0;
  assign bufBase[1] = cfgBufBase1;
  assign dstBase    = bufBase[strb.fillSel];
  assign srcAddr    = cfgSrcBase + blkOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkOff <= '0;
      wrEn   <= 1'b0;
      wrBuf  <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strb.accept;
      if (strb.accept) begin
        wrAddr <= dstBase + blkOff;
        wrData <= inData;
        wrBuf  <= strb.fillSel;
      end
      if (strb.restart || strb.blockEnd) blkOff <= '0;
      else if (strb.accept)              blkOff <= blkOff + STEP;
    end
  end

  // R2: each acceptance yields one write of the accepted sample
  p_write_tracks_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> wrEn && (wrData == $past(inData)));

  // R9: no write follows a disabled cycle
  p_no_write_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> !wrEn);

  // R6: the write after a block end lands at the new buffer base
  p_restart_at_base_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && $past(strb.blockEnd)) |=> wrAddr == $past(dstBase));

endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
  import pp_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] cfgSrcBase,
  input  logic [ADDR_W-1:0] cfgBufBase0,
  input  logic [ADDR_W-1:0] cfgBufBase1,
  input  logic [CNT_W-1:0]  cfgElemCount,
  input  logic [CNT_W-1:0]  cfgFrameCount,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              wrEn,
  output logic              wrBuf,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              frameDone,
  output logic              blockDone,
  output logic              fillBuf,
  output logic              readyBuf,
  input  logic              procAck,
  output logic              overrun
);

  ppStrobe_t strb;

  pp_dma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgEnable    (cfgEnable),
    .cfgElemCount (cfgElemCount),
    .cfgFrameCount(cfgFrameCount),
    .inValid      (inValid),
    .procAck      (procAck),
    .inReady      (inReady),
    .strb         (strb),
    .frameDone    (frameDone),
    .blockDone    (blockDone),
    .fillBuf      (fillBuf),
    .readyBuf     (readyBuf),
    .overrun      (overrun)
  );

  pp_dma_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inData     (inData),
    .cfgSrcBase (cfgSrcBase),
    .cfgBufBase0(cfgBufBase0),
    .cfgBufBase1(cfgBufBase1),
    .srcAddr    (srcAddr),
    .wrEn       (wrEn),
    .wrBuf      (wrBuf),
    .wrAddr     (wrAddr),
    .wrData     (wrData)
  );

  // R3: write buffer number matches the buffer being filled before the edge
  p_wr_in_fill_buf_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrBuf == $past(fillBuf));

endmodule

// File: tb/pingpong_dma_bench.sv
module pingpong_dma_bench;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [ADDR_W-1:0] SRC  = 8'h40;
  localparam logic [ADDR_W-1:0] BAS0 = 8'h10;
  localparam logic [ADDR_W-1:0] BAS1 = 8'hF8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0;
  logic [CNT_W-1:0] cfgElemCount = 4'd1;
  logic [CNT_W-1:0] cfgFrameCount = 4'd1;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic procAck = 1'b0;
  logic inReady, wrEn, wrBuf, frameDone, blockDone, fillBuf, readyBuf, overrun;
  logic [ADDR_W-1:0] srcAddr, wrAddr;
  logic [DATA_W-1:0] wrData;

  always #10 clk = ~clk;

  pingpong_dma #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pingpong_dma (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgSrcBase(SRC),
    .cfgBufBase0(BAS0), .cfgBufBase1(BAS1), .cfgElemCount(cfgElemCount),
    .cfgFrameCount(cfgFrameCount), .inValid(inValid), .inData(inData),
    .inReady(inReady), .srcAddr(srcAddr), .wrEn(wrEn), .wrBuf(wrBuf),
    .wrAddr(wrAddr), .wrData(wrData), .frameDone(frameDone),
    .blockDone(blockDone), .fillBuf(fillBuf), .readyBuf(readyBuf),
    .procAck(procAck), .overrun(overrun)
  );

  int nChecks = 0;
  int nFails  = 0;
  int mE, mF, mElem, mFrm, mBlocks;
  bit mFill, mReady, mPend, mOv;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic restart(input int e, input int f);
    cfgEnable = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b0, "R9 inReady low when disabled", int'(inReady), 0);
    chk(wrEn == 1'b0, "R9 no write while disabled", int'(wrEn), 0);
    chk(fillBuf == 1'b0 && readyBuf == 1'b0, "R9 buffers cleared",
        int'({fillBuf, readyBuf}), 0);
    chk(overrun == 1'b0, "R9 overrun cleared", int'(overrun), 0);
    inValid = 1'b0;
    cfgElemCount = CNT_W'(e);
    cfgFrameCount = CNT_W'(f);
    cfgEnable = 1'b1;
    mE = e; mF = f; mElem = 0; mFrm = 0; mBlocks = 0;
    mFill = 0; mReady = 0; mPend = 0; mOv = 0;
  endtask

  task automatic sendOne(input logic [DATA_W-1:0] d, input bit ack, input int gap);
    logic [ADDR_W-1:0] expSrc, expWr;
    bit expFrame, expBlock, wasFill;
    inValid = 1'b1;
    inData = d;
    procAck = ack;
    expSrc = ADDR_W'(int'(SRC) + mFrm * mE + mElem);
    chk(srcAddr == expSrc, "R7 srcAddr", int'(srcAddr), int'(expSrc));
    chk(inReady == 1'b1, "R2 inReady when enabled", int'(inReady), 1);
    wasFill = mFill;
    expWr = ADDR_W'(int'(mFill ? BAS1 : BAS0) + mFrm * mE + mElem);
    expFrame = (mElem == mE - 1);
    expBlock = expFrame && (mFrm == mF - 1);
    @(negedge clk);
    inValid = 1'b0;
    procAck = 1'b0;
    chk(wrEn == 1'b1, "R2 write strobe", int'(wrEn), 1);
    chk(wrData == d, "R2 write data", int'(wrData), int'(d));
    chk(wrAddr == expWr, "R3 write address", int'(wrAddr), int'(expWr));
    chk(wrBuf == wasFill, "R3 write buffer", int'(wrBuf), int'(wasFill));
    if (mElem == 0 && mFrm == 0 && mBlocks > 0)
      chk(wrAddr == (wasFill ? BAS1 : BAS0), "R6 first write at new base",
          int'(wrAddr), int'(wasFill ? BAS1 : BAS0));
    chk(frameDone == expFrame, "R4 frameDone", int'(frameDone), int'(expFrame));
    chk(blockDone == expBlock, "R5 blockDone", int'(blockDone), int'(expBlock));
    if (expBlock) begin
      mOv = mOv | (mPend & ~ack);
      mPend = 1;
      mReady = mFill;
      mFill = ~mFill;
      mElem = 0; mFrm = 0;
      mBlocks++;
    end else begin
      if (ack) mPend = 0;
      if (expFrame) begin mElem = 0; mFrm++; end
      else mElem++;
    end
    chk(fillBuf == mFill, "R5 fillBuf", int'(fillBuf), int'(mFill));
    chk(readyBuf == mReady, "R5 readyBuf", int'(readyBuf), int'(mReady));
    chk(overrun == mOv, "R8 overrun", int'(overrun), int'(mOv));
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(wrEn == 1'b0 && frameDone == 1'b0 && blockDone == 1'b0,
          "R10 idle cycle quiet", int'({wrEn, frameDone, blockDone}), 0);
    end
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nChecks, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wrEn == 0 && frameDone == 0 && blockDone == 0, "R1 pulses low after reset",
        int'({wrEn, frameDone, blockDone}), 0);
    chk(overrun == 0 && fillBuf == 0 && readyBuf == 0, "R1 state low after reset",
        int'({overrun, fillBuf, readyBuf}), 0);

    // Sweep of frame/block shapes, acks in time, mixed gaps
    for (int e = 1; e <= 4; e++) begin
      for (int f = 1; f <= 3; f++) begin
        restart(e, f);
        for (int i = 0; i < 2 * e * f + 2; i++) begin
          sendOne(DATA_W'((e << 12) | (f << 8) | i), (mElem == 0 && mFrm == 0),
                  (i % 3 == 2) ? 1 : 0);
        end
        chk(overrun == 1'b0, "R8 no overrun with timely ack", int'(overrun), 0);
      end
    end

    // R8 late acknowledgement: second block end without ack
    restart(2, 2);
    for (int i = 0; i < 8; i++) sendOne(DATA_W'(16'hA000 + i), 1'b0, 0);
    chk(overrun == 1'b1, "R8 overrun set on unacked swap", int'(overrun), 1);
    chk(mBlocks == 2 && fillBuf == 1'b0, "R8 swap still happened", int'(fillBuf), 0);
    for (int i = 0; i < 4; i++) sendOne(DATA_W'(16'hB000 + i), (i == 0), 0);
    chk(overrun == 1'b1, "R8 overrun is sticky", int'(overrun), 1);

    // R8 ack in the completing cycle counts; stray ack has no effect
    restart(1, 2);
    sendOne(16'hC000, 1'b1, 0); // stray ack, nothing outstanding
    sendOne(16'hC001, 1'b0, 0); // block 1 ends
    sendOne(16'hC002, 1'b0, 0);
    sendOne(16'hC003, 1'b1, 0); // block 2 ends, ack same cycle
    chk(overrun == 1'b0, "R8 same-cycle ack in time", int'(overrun), 0);
    sendOne(16'hC004, 1'b0, 1);
    sendOne(16'hC005, 1'b0, 0); // block 3 ends, block 2 unacked
    chk(overrun == 1'b1, "R8 overrun after missing ack", int'(overrun), 1);

    // R9 restart clears everything, next write at buffer 0 base
    restart(3, 1);
    sendOne(16'hD000, 1'b0, 0);
    chk(wrAddr == BAS0, "R9 restart begins at buffer 0 base", int'(wrAddr), int'(BAS0));

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule